// File: doc/BRIEF.md
# Condition Flag and Branch Decision Unit

This block keeps the processor's three condition flags (negative, zero, positive) and decides whether a conditional branch is taken. When the control logic requests a flag update and the current opcode is one of the register-writing operations, the unit reads the 16-bit result as a two's-complement number. It then stores exactly one of the three flags. Stores, branches, jumps and traps leave the flags alone even if the update request is raised.

A branch decision port takes the three select bits of a branch instruction and reports taken when any selected flag is currently set. With no bit selected the branch is never taken. With all three selected it is always taken. A helper output tells the rest of the control path whether the presented opcode is one that writes the flags. The asynchronous reset is released through a two-stage synchronizer, and the flags come out of reset holding zero.

Top module: `cond_branch_unit`

## Requirements
- R1: While reset is asserted, and until the first qualifying update after reset, the flag output `flags_o` reads 3'b010 (bit 2 = negative, bit 1 = zero, bit 0 = positive).
- R2: Exactly one bit of `flags_o` is set in every cycle.
- R3: A qualifying update with bit 15 of the result set makes `flags_o` equal 3'b100 from the cycle after the update edge.
- R4: A qualifying update with a result of 16'h0000 makes `flags_o` equal 3'b010 from the cycle after the update edge.
- R5: A qualifying update with a nonzero result whose bit 15 is clear makes `flags_o` equal 3'b001 from the cycle after the update edge.
- R6: While `cc_load_i` is low, `flags_o` keeps its value whatever `result_i` and `opcode_i` carry.
- R7: With `cc_load_i` high and an opcode for which `op_sets_cc_o` is low, `flags_o` keeps its value.
- R8: `op_sets_cc_o` is high exactly for the opcodes 4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b1010, 4'b0110 and 4'b1110, and low for the other nine codes.
- R9: `taken_o` is high when any bit of `br_sel_i` (bit 2 = negative, bit 1 = zero, bit 0 = positive) meets a set bit of `flags_o` in the same cycle, with no added latency.
- R10: A select of 3'b000 never gives `taken_o` high, and a select of 3'b111 always does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| result_i | input | 16 | Result value observed for flag classification |
| cc_load_i | input | 1 | Flag update request from control |
| opcode_i | input | 4 | Opcode of the instruction in execution |
| br_sel_i | input | 3 | Branch select bits {negative, zero, positive} |
| op_sets_cc_o | output | 1 | Presented opcode is a flag-writing opcode |
| flags_o | output | 3 | Stored flags {negative, zero, positive} |
| taken_o | output | 1 | Branch decision for the current select |

## Verification
The classifier is driven with the edge values 16'h8000, 16'hFFFF, 16'h0000, 16'h0001, 16'h7FFF and a mid-range positive value. These separate a sign-bit test from a magnitude test and catch an off-by-one at the zero boundary. Updates come from flag-writing opcodes and are interleaved with store, branch and other non-writing opcodes, which shows whether the opcode qualification gates the register. The branch select is swept over single-bit, two-bit, empty and full masks against each flag state, which separates an any-match decision from an all-match or equality decision. All sixteen opcodes are presented to the helper output.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned CC_W   = 3;

  // Bit positions inside the flag vector, also used by the branch select
  localparam int unsigned CC_NEG = 2;
  localparam int unsigned CC_ZER = 1;
  localparam int unsigned CC_POS = 0;

  // One bit per opcode value: set where the opcode writes the flags
  // (codes 1, 2, 5, 6, 9, 10, 14)
  localparam logic [(1 << OP_W)-1:0] CC_OP_MASK = 16'h4666;

  localparam logic [CC_W-1:0] CC_RESET = 3'b010;

  typedef logic [CC_W-1:0] cc_t;
endpackage

// File: rtl/ccb_rst_sync.sv
module ccb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/ccb_classify.sv
module ccb_classify
  import ccb_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] value_i,
  output cc_t              cc_o
);
  localparam int unsigned SIGN = WIDTH - 1;

  logic is_neg;
  logic is_zero;

  always_comb begin
    is_neg  = value_i[SIGN];
    is_zero = (value_i == '0);
    cc_o         = '0;
    cc_o[CC_NEG] = is_neg;
    cc_o[CC_ZER] = is_zero;
    cc_o[CC_POS] = !is_neg && !is_zero;
  end
endmodule

// File: rtl/ccb_op_filter.sv
module ccb_op_filter
  import ccb_pkg::*;
#(
  parameter int unsigned            OPW  = OP_W,
  parameter logic [(1 << OPW)-1:0]  MASK = CC_OP_MASK
) (
  input  logic [OPW-1:0] opcode_i,
  output logic           sets_cc_o
);
  localparam int unsigned NCODES = 1 << OPW;

  logic [NCODES-1:0] hit;

  for (genvar g = 0; g < NCODES; g++) begin : g_code
    if (MASK[g]) begin : g_on
      assign hit[g] = (opcode_i == g[OPW-1:0]);
    end else begin : g_off
      assign hit[g] = 1'b0;
    end
  end

  assign sets_cc_o = |hit;
endmodule

// File: rtl/ccb_branch_eval.sv
module ccb_branch_eval
  import ccb_pkg::*;
(
  input  cc_t  sel_i,
  input  cc_t  cc_i,
  output logic taken_o
);
  cc_t match;

  for (genvar g = 0; g < CC_W; g++) begin : g_bit
    assign match[g] = sel_i[g] & cc_i[g];
  end

  assign taken_o = |match;
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import ccb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] result_i,
  input  logic              cc_load_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [CC_W-1:0]   br_sel_i,
  output logic              op_sets_cc_o,
  output logic [CC_W-1:0]   flags_o,
  output logic              taken_o
);
  logic rst_q_n;
  cc_t  cc_q;
  cc_t  cc_d;
  cc_t  cc_new;
  logic cc_en;

  ccb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  ccb_classify #(.WIDTH(DATA_W)) u_cls (
    .value_i (result_i),
    .cc_o    (cc_new)
  );

  ccb_op_filter #(.OPW(OP_W), .MASK(CC_OP_MASK)) u_opf (
    .opcode_i  (opcode_i),
    .sets_cc_o (op_sets_cc_o)
  );

  // Next-state logic: clock enable written out explicitly
  always_comb begin
    cc_en = cc_load_i & op_sets_cc_o;
    cc_d  = cc_q;
    if (cc_en) begin
      cc_d = cc_new;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cc_q <= CC_RESET;
    end else begin
      cc_q <= cc_d;
    end
  end

  ccb_branch_eval u_br (
    .sel_i   (br_sel_i),
    .cc_i    (cc_q),
    .taken_o (taken_o)
  );

  assign flags_o = cc_q;
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic [15:0] result_i,
  input logic        cc_load_i,
  input logic [3:0]  opcode_i,
  input logic [2:0]  br_sel_i,
  input logic        op_sets_cc_o,
  input logic [2:0]  flags_o,
  input logic        taken_o
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(flags_o) == 1);

  p_neg_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cc_load_i && op_sets_cc_o && result_i[15]) |=> (flags_o == 3'b100));

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cc_load_i && op_sets_cc_o && result_i == 16'h0000) |=> (flags_o == 3'b010));

  p_pos_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cc_load_i && op_sets_cc_o && !result_i[15] && result_i != 16'h0000)
      |=> (flags_o == 3'b001));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cc_load_i |=> $stable(flags_o));

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cc_load_i && !op_sets_cc_o) |=> $stable(flags_o));

  p_never_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (br_sel_i == 3'b000) |-> !taken_o);

  p_always_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (br_sel_i == 3'b111) |-> taken_o);
endmodule

bind cond_branch_unit cond_branch_unit_chk u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .result_i     (result_i),
  .cc_load_i    (cc_load_i),
  .opcode_i     (opcode_i),
  .br_sel_i     (br_sel_i),
  .op_sets_cc_o (op_sets_cc_o),
  .flags_o      (flags_o),
  .taken_o      (taken_o)
);

// File: tb/cond_branch_unit_tb_top.sv
module cond_branch_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] result_i;
  logic        cc_load_i;
  logic [3:0]  opcode_i;
  logic [2:0]  br_sel_i;
  logic        op_sets_cc_o;
  logic [2:0]  flags_o;
  logic        taken_o;

  int checks;
  int fails;
  bit done;

  // {opcode, result, select, expected flags, expected taken}
  localparam int NVEC = 10;
  localparam logic [26:0] VEC [0:NVEC-1] = '{
    {4'h1, 16'h8000, 3'b100, 3'b100, 1'b1},
    {4'h5, 16'h0000, 3'b100, 3'b010, 1'b0},
    {4'h9, 16'h0001, 3'b011, 3'b001, 1'b1},
    {4'h3, 16'hFFFF, 3'b001, 3'b001, 1'b1},
    {4'h2, 16'hFFFF, 3'b110, 3'b100, 1'b1},
    {4'hA, 16'h7FFF, 3'b110, 3'b001, 1'b0},
    {4'h6, 16'h0000, 3'b101, 3'b010, 1'b0},
    {4'hE, 16'h3102, 3'b010, 3'b001, 1'b0},
    {4'h0, 16'h0000, 3'b001, 3'b001, 1'b1},
    {4'hC, 16'h8000, 3'b000, 3'b001, 1'b0}
  };

  cond_branch_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .result_i     (result_i),
    .cc_load_i    (cc_load_i),
    .opcode_i     (opcode_i),
    .br_sel_i     (br_sel_i),
    .op_sets_cc_o (op_sets_cc_o),
    .flags_o      (flags_o),
    .taken_o      (taken_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one update with the given opcode, then move to the next negedge
  task automatic update(input logic [3:0] op, input logic [15:0] val);
    opcode_i  = op;
    result_i  = val;
    cc_load_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cc_load_i = 1'b0;
  endtask

  initial begin
    rst_n     = 1'b0;
    result_i  = 16'h0000;
    cc_load_i = 1'b0;
    opcode_i  = 4'h0;
    br_sel_i  = 3'b000;
    repeat (3) @(negedge clk);
    check("R1 reset flags", {13'd0, flags_o}, 16'h0002);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 flags after reset release", {13'd0, flags_o}, 16'h0002);
    br_sel_i = 3'b010;
    #1 check("R9 taken on zero after reset", {15'd0, taken_o}, 16'h0001);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      update(VEC[i][26:23], VEC[i][22:7]);
      br_sel_i = VEC[i][6:4];
      #1;
      check($sformatf("R3/R4/R5/R7 flags row %0d", i), {13'd0, flags_o}, {13'd0, VEC[i][3:1]});
      check($sformatf("R9 taken row %0d", i), {15'd0, taken_o}, {15'd0, VEC[i][0]});
      check("R2 one-hot", 16'($countones(flags_o)), 16'd1);
    end

    // R8: helper over all opcodes
    for (int op = 0; op < 16; op++) begin
      logic exp_h;
      exp_h = (op == 1) || (op == 5) || (op == 9) || (op == 2) ||
              (op == 10) || (op == 6) || (op == 14);
      opcode_i = op[3:0];
      #1 check($sformatf("R8 helper op %0d", op), {15'd0, op_sets_cc_o}, {15'd0, exp_h});
    end

    // R6: no load, result and opcode change, flags hold (currently 001)
    update(4'h1, 16'hFFFF);
    check("R3 negative set", {13'd0, flags_o}, 16'h0004);
    opcode_i = 4'h1;
    result_i = 16'h0000;
    repeat (2) @(negedge clk);
    check("R6 hold with load low", {13'd0, flags_o}, 16'h0004);

    // R7: load high with non-writing opcodes (store, branch, trap, jump)
    update(4'h3, 16'h0000);
    update(4'h0, 16'h0005);
    update(4'hF, 16'h0000);
    update(4'hC, 16'h0001);
    check("R7 non-writing opcodes ignored", {13'd0, flags_o}, 16'h0004);

    // R10 and R9 sweep over every flag state
    for (int s = 0; s < 3; s++) begin
      logic [15:0] val;
      logic [2:0]  fl;
      val = (s == 0) ? 16'h8001 : (s == 1) ? 16'h0000 : 16'h0042;
      fl  = (s == 0) ? 3'b100 : (s == 1) ? 3'b010 : 3'b001;
      update(4'h5, val);
      check("R3/R4/R5 sweep flags", {13'd0, flags_o}, {13'd0, fl});
      for (int m = 0; m < 8; m++) begin
        br_sel_i = m[2:0];
        #1 check($sformatf("R9/R10 sel %0d state %0d", m, s), {15'd0, taken_o},
                 {15'd0, |(m[2:0] & fl)});
      end
    end

    // R1 again: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async reset", {13'd0, flags_o}, 16'h0002);
    done = 1'b1;
  end

  initial begin
    done = 1'b0;
    checks = 0;
    fails = 0;
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule